// File: doc/BRIEF.md
# Memory-to-Memory Bus DMA Engine with Retry Backoff

This block copies a run of words from one memory region to another over WISHBONE-style buses. A host programs a source byte address, a destination byte address and a word count through a 32-bit slave control port. It then writes a command that starts the copy. The engine moves one word at a time: it fetches the word through a master read port, holds it in a one-word buffer, and stores it through a master write port. After each accepted store, both addresses advance by the word size in bytes and the remaining count drops by one.

Targets may answer a cycle with acknowledge, retry or error. After a retry, the engine lowers its strobe for a programmable number of cycles and then repeats exactly the same cycle. An error ends the copy at once, and a sticky error flag records it.

The command selects one of two modes. In single mode, each bus cycle is framed on its own. In incrementing-burst mode, both ports keep their cycle line raised for the whole copy and tag each beat with a cycle-type code.

Top module: `dma_engine`

## Requirements
- R1: After reset all master cycle and strobe outputs are low, the control acknowledge is low, and the status register and both address registers read zero.
- R2: Each control access is acknowledged with `ctl_ack_o` high for one cycle, one cycle after it is accepted. Index 0 holds the source address, index 1 the destination address and index 2 the word count (low LENW bits). Index 3 reads status with busy at bit 0, done at bit 1, error at bit 2 and burst mode at bit 3. A read returns the register value in the cycle the access is accepted.
- R3: Writing index 3 with bit 0 set while idle starts a copy. Bit 1 of that write selects burst mode. Starting clears done and error.
- R4: Word i is read from source + i·(DW/8) and the same data is written to destination + i·(DW/8). After each accepted write, both address registers advance by DW/8 and the count decrements by one. When the count reaches zero, done is set and busy clears.
- R5: A start with a count of zero sets done at once and raises no cycle or strobe on either master port.
- R6: A strobe stays high, with its address (and write data) unchanged, until acknowledge, retry or error arrives. The read and write strobes are never high together.
- R7: After a retry, the strobe of that port is low for exactly RETRY_WAIT cycles. The same cycle is then reissued with the same address and data. This holds on both ports and in both modes.
- R8: A retry that arrives during the backoff wait restarts the wait, so the strobe stays low for RETRY_WAIT further cycles from that point.
- R9: An error on either port drops both cycle lines in the next cycle, clears busy, sets the error flag and leaves done clear. The failing word does not advance the addresses or the count.
- R10: While busy, writes to indices 0 to 3 (including start) have no effect.
- R11: In burst mode both cycle lines stay high while any strobe is high. The cycle-type output is 3'b010 for every beat except the last word, which carries 3'b111. In single mode the cycle-type output is 3'b000, and the idle port's cycle line is low while the other port strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_cyc_i | input | 1 | Control port cycle |
| ctl_stb_i | input | 1 | Control port strobe |
| ctl_we_i | input | 1 | Control port write enable |
| ctl_adr_i | input | 2 | Control register index |
| ctl_dat_i | input | 32 | Control write data |
| ctl_dat_o | output | 32 | Control read data |
| ctl_ack_o | output | 1 | Control acknowledge |
| rd_cyc_o | output | 1 | Read master cycle |
| rd_stb_o | output | 1 | Read master strobe |
| rd_adr_o | output | AW | Read byte address |
| rd_cti_o | output | 3 | Read cycle-type code |
| rd_dat_i | input | DW | Read data |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_rty_i | input | 1 | Read retry |
| rd_err_i | input | 1 | Read error |
| wr_cyc_o | output | 1 | Write master cycle |
| wr_stb_o | output | 1 | Write master strobe |
| wr_adr_o | output | AW | Write byte address |
| wr_cti_o | output | 3 | Write cycle-type code |
| wr_dat_o | output | DW | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_rty_i | input | 1 | Write retry |
| wr_err_i | input | 1 | Write error |

## Verification
The copy is run with plain zero-wait targets and with targets that insert one wait state per cycle. The wait-state case shows whether strobes, addresses and data are held until a response arrives. Retries are injected on chosen words of either port, and one extra retry is placed inside a backoff window. These runs measure the strobe gap exactly, separating a correct wait from an off-by-one or a missing reload, and show whether the retried address is repeated rather than skipped. Burst runs check the cycle-type codes against the words still to go. Error runs on the read side and on the write side show whether the failing word is counted or not. A zero count, and writes made during a busy copy, check that nothing moves when nothing should.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD      = 3'd1,
        ST_RD_BACK = 3'd2,
        ST_WR      = 3'd3,
        ST_WR_BACK = 3'd4
    } dma_state_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_LAST    = 3'b111;

    localparam logic [1:0] IDX_SRC  = 2'd0;
    localparam logic [1:0] IDX_DST  = 2'd1;
    localparam logic [1:0] IDX_LEN  = 2'd2;
    localparam logic [1:0] IDX_CMD  = 2'd3;

endpackage

// File: rtl/dma_backoff.sv
module dma_backoff #(
    parameter int WAIT_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(WAIT_CYC);
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_ctl_port.sv
module dma_ctl_port
    import dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LENW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic            we_i,
    input  logic [1:0]      adr_i,
    input  logic [AW-1:0]   src_i,
    input  logic [AW-1:0]   dst_i,
    input  logic [LENW-1:0] len_i,
    input  logic [3:0]      status_i,
    output logic [31:0]     dat_o,
    output logic            ack_o,
    output logic            wr_src_o,
    output logic            wr_dst_o,
    output logic            wr_len_o,
    output logic            wr_cmd_o
);
    typedef struct packed {
        logic        ack;
        logic [31:0] dat;
    } port_t;

    port_t q, d;
    logic  accept;
    logic [31:0] rsel;

    always_comb begin
        accept = cyc_i && stb_i && !q.ack;
        rsel   = '0;
        case (adr_i)
            IDX_SRC: rsel[AW-1:0]   = src_i;
            IDX_DST: rsel[AW-1:0]   = dst_i;
            IDX_LEN: rsel[LENW-1:0] = len_i;
            default: rsel[3:0]      = status_i;
        endcase
        d.ack = accept;
        d.dat = (accept && !we_i) ? rsel : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign wr_src_o = accept && we_i && (adr_i == IDX_SRC);
    assign wr_dst_o = accept && we_i && (adr_i == IDX_DST);
    assign wr_len_o = accept && we_i && (adr_i == IDX_LEN);
    assign wr_cmd_o = accept && we_i && (adr_i == IDX_CMD);
    assign ack_o    = q.ack;
    assign dat_o    = q.dat;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int LENW       = 16,
    parameter int RETRY_WAIT = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ctl_cyc_i,
    input  logic          ctl_stb_i,
    input  logic          ctl_we_i,
    input  logic [1:0]    ctl_adr_i,
    input  logic [31:0]   ctl_dat_i,
    output logic [31:0]   ctl_dat_o,
    output logic          ctl_ack_o,
    output logic          rd_cyc_o,
    output logic          rd_stb_o,
    output logic [AW-1:0] rd_adr_o,
    output logic [2:0]    rd_cti_o,
    input  logic [DW-1:0] rd_dat_i,
    input  logic          rd_ack_i,
    input  logic          rd_rty_i,
    input  logic          rd_err_i,
    output logic          wr_cyc_o,
    output logic          wr_stb_o,
    output logic [AW-1:0] wr_adr_o,
    output logic [2:0]    wr_cti_o,
    output logic [DW-1:0] wr_dat_o,
    input  logic          wr_ack_i,
    input  logic          wr_rty_i,
    input  logic          wr_err_i
);
    localparam int            BYTES = DW / 8;
    localparam logic [AW-1:0] STEP  = AW'(BYTES);

    typedef struct packed {
        dma_state_e      st;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [LENW-1:0] len;
        logic [DW-1:0]   word;
        logic            done;
        logic            err;
        logic            burst;
    } eng_t;

    eng_t q, d;

    logic wr_src, wr_dst, wr_len, wr_cmd;
    logic rd_load, rd_run, rd_last;
    logic wr_load, wr_run, wr_last;
    logic busy_w, err_w;
    logic [LENW-1:0] len_w;
    logic [2:0] cti_now;
    logic [3:0] status;

    dma_ctl_port #(.AW(AW), .LENW(LENW)) u_ctl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cyc_i    (ctl_cyc_i),
        .stb_i    (ctl_stb_i),
        .we_i     (ctl_we_i),
        .adr_i    (ctl_adr_i),
        .src_i    (q.src),
        .dst_i    (q.dst),
        .len_i    (q.len),
        .status_i (status),
        .dat_o    (ctl_dat_o),
        .ack_o    (ctl_ack_o),
        .wr_src_o (wr_src),
        .wr_dst_o (wr_dst),
        .wr_len_o (wr_len),
        .wr_cmd_o (wr_cmd)
    );

    dma_backoff #(.WAIT_CYC(RETRY_WAIT)) u_rd_backoff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (rd_load),
        .run_i  (rd_run),
        .last_o (rd_last)
    );

    dma_backoff #(.WAIT_CYC(RETRY_WAIT)) u_wr_backoff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (wr_load),
        .run_i  (wr_run),
        .last_o (wr_last)
    );

    always_comb begin
        d       = q;
        rd_load = 1'b0;
        rd_run  = 1'b0;
        wr_load = 1'b0;
        wr_run  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (wr_src) d.src = ctl_dat_i[AW-1:0];
                if (wr_dst) d.dst = ctl_dat_i[AW-1:0];
                if (wr_len) d.len = ctl_dat_i[LENW-1:0];
                if (wr_cmd && ctl_dat_i[0]) begin
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                    d.burst = ctl_dat_i[1];
                    if (q.len == '0) d.done = 1'b1;
                    else             d.st   = ST_RD;
                end
            end
            ST_RD: begin
                if (rd_err_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else if (rd_ack_i) begin
                    d.word = rd_dat_i;
                    d.st   = ST_WR;
                end else if (rd_rty_i) begin
                    rd_load = 1'b1;
                    d.st    = ST_RD_BACK;
                end
            end
            ST_RD_BACK: begin
                rd_run = 1'b1;
                if (rd_rty_i)     rd_load = 1'b1;
                else if (rd_last) d.st    = ST_RD;
            end
            ST_WR: begin
                if (wr_err_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else if (wr_ack_i) begin
                    d.src = q.src + STEP;
                    d.dst = q.dst + STEP;
                    d.len = q.len - LENW'(1);
                    if (q.len == LENW'(1)) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st = ST_RD;
                    end
                end else if (wr_rty_i) begin
                    wr_load = 1'b1;
                    d.st    = ST_WR_BACK;
                end
            end
            ST_WR_BACK: begin
                wr_run = 1'b1;
                if (wr_rty_i)     wr_load = 1'b1;
                else if (wr_last) d.st    = ST_WR;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_w = (q.st != ST_IDLE);
    assign err_w  = q.err;
    assign len_w  = q.len;
    assign status = {q.burst, q.err, q.done, busy_w};

    always_comb begin
        if (!q.burst)             cti_now = CTI_CLASSIC;
        else if (q.len == LENW'(1)) cti_now = CTI_LAST;
        else                      cti_now = CTI_INCR;
    end

    assign rd_stb_o = (q.st == ST_RD);
    assign wr_stb_o = (q.st == ST_WR);
    assign rd_cyc_o = q.burst ? busy_w : (q.st == ST_RD || q.st == ST_RD_BACK);
    assign wr_cyc_o = q.burst ? busy_w : (q.st == ST_WR || q.st == ST_WR_BACK);
    assign rd_adr_o = q.src;
    assign wr_adr_o = q.dst;
    assign wr_dat_o = q.word;
    assign rd_cti_o = cti_now;
    assign wr_cti_o = cti_now;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int LENW       = 16,
    parameter int RETRY_WAIT = 16
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            rd_cyc_o,
    input logic            rd_stb_o,
    input logic [AW-1:0]   rd_adr_o,
    input logic            rd_ack_i,
    input logic            rd_rty_i,
    input logic            rd_err_i,
    input logic            wr_cyc_o,
    input logic            wr_stb_o,
    input logic [AW-1:0]   wr_adr_o,
    input logic [DW-1:0]   wr_dat_o,
    input logic            wr_ack_i,
    input logic            wr_rty_i,
    input logic            wr_err_i,
    input logic            busy_w,
    input logic            err_w,
    input logic [LENW-1:0] len_w
);
    logic        after_q;
    logic        skip_q;
    logic [15:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            after_q <= 1'b0;
            skip_q  <= 1'b0;
            gap_q   <= '0;
        end else if (rd_stb_o) begin
            after_q <= rd_rty_i && !rd_ack_i && !rd_err_i;
            skip_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            if (after_q)  gap_q  <= gap_q + 16'd1;
            if (rd_rty_i) skip_q <= 1'b1;
        end
    end

    // R6
    a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stb_o && !rd_ack_i && !rd_rty_i && !rd_err_i |=> rd_stb_o && $stable(rd_adr_o));

    // R6
    a_r6_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o && !wr_ack_i && !wr_rty_i && !wr_err_i
        |=> wr_stb_o && $stable(wr_adr_o) && $stable(wr_dat_o));

    // R6
    a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_stb_o && wr_stb_o));

    // R7
    a_r7_rd_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stb_o && rd_rty_i && !rd_ack_i && !rd_err_i |=> !rd_stb_o && $stable(rd_adr_o));

    // R7
    a_r7_backoff_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_stb_o) && after_q && !skip_q |-> gap_q == 16'(RETRY_WAIT));

    // R9
    a_r9_rd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stb_o && rd_err_i |=> !rd_cyc_o && !wr_cyc_o && !busy_w && err_w);

    // R9
    a_r9_wr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o && wr_err_i |=> !rd_cyc_o && !wr_cyc_o && !busy_w && err_w
                                 && len_w == $past(len_w));

    // R4
    a_r4_len_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o && wr_ack_i && !wr_err_i |=> len_w == $past(len_w) - LENW'(1));
endmodule

bind dma_engine dma_engine_chk #(
    .DW(DW), .AW(AW), .LENW(LENW), .RETRY_WAIT(RETRY_WAIT)
) u_chk (.*);

// File: tb/dma_engine_test.sv
module dma_engine_test;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int LENW = 16;
    localparam int RW = 5;
    localparam int BY = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        ctl_cyc = 0, ctl_stb = 0, ctl_we = 0;
    logic [1:0]  ctl_adr = '0;
    logic [31:0] ctl_wdat = '0;
    logic [31:0] ctl_rdat;
    logic        ctl_ack;
    logic rd_cyc, rd_stb, wr_cyc, wr_stb;
    logic [AW-1:0] rd_adr, wr_adr;
    logic [2:0] rd_cti, wr_cti;
    logic [DW-1:0] rd_dat = '0;
    logic [DW-1:0] wr_dat;
    logic rd_ack = 0, rd_rty = 0, rd_err = 0;
    logic wr_ack = 0, wr_rty = 0, wr_err = 0;

    dma_engine #(.DW(DW), .AW(AW), .LENW(LENW), .RETRY_WAIT(RW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .ctl_cyc_i(ctl_cyc), .ctl_stb_i(ctl_stb), .ctl_we_i(ctl_we),
        .ctl_adr_i(ctl_adr), .ctl_dat_i(ctl_wdat), .ctl_dat_o(ctl_rdat), .ctl_ack_o(ctl_ack),
        .rd_cyc_o(rd_cyc), .rd_stb_o(rd_stb), .rd_adr_o(rd_adr), .rd_cti_o(rd_cti),
        .rd_dat_i(rd_dat), .rd_ack_i(rd_ack), .rd_rty_i(rd_rty), .rd_err_i(rd_err),
        .wr_cyc_o(wr_cyc), .wr_stb_o(wr_stb), .wr_adr_o(wr_adr), .wr_cti_o(wr_cti),
        .wr_dat_o(wr_dat), .wr_ack_i(wr_ack), .wr_rty_i(wr_rty), .wr_err_i(wr_err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    function automatic void chk(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic logic [DW-1:0] srcdat(logic [31:0] a);
        logic [31:0] v;
        v = a * 32'h9E37_79B9 + 32'h0000_1234;
        return v[DW-1:0];
    endfunction

    // reference model state
    logic [31:0] ex_src, ex_dst;
    int ex_len;
    bit burst_mode = 0, slow = 0, quiet = 0;
    int rd_idx = 0, wr_idx = 0;
    int rd_err_idx = -1, wr_err_idx = -1;
    int rd_rty_word = -1, rd_rty_times = 0, rd_rty_cnt = 0, rd_reload_at = 0;
    int wr_rty_word = -1, wr_rty_times = 0, wr_rty_cnt = 0;
    bit rd_held = 0, wr_held = 0, rd_gap_on = 0, wr_gap_on = 0, err_last = 0;
    int rd_gap = 0, wr_gap = 0, rd_gap_exp = 0, wr_gap_exp = 0;

    function automatic logic [2:0] cti_exp(int idx);
        if (!burst_mode) return 3'b000;
        return (ex_len - idx == 1) ? 3'b111 : 3'b010;
    endfunction

    always @(negedge clk) begin
        rd_ack = 0; rd_rty = 0; rd_err = 0;
        wr_ack = 0; wr_rty = 0; wr_err = 0;
        if (rst_n) begin
            if (err_last) begin
                chk(!rd_cyc && !wr_cyc, "R9 cyc after error", {rd_cyc, wr_cyc}, 0);
                err_last = 0;
            end
            if (quiet) chk(!rd_cyc && !wr_cyc, "R5 no bus activity", {rd_cyc, wr_cyc}, 0);
            chk(!(rd_stb && wr_stb), "R6 strobes exclusive", {rd_stb, wr_stb}, 0);
            if (rd_stb || wr_stb) begin
                if (burst_mode)
                    chk(rd_cyc && wr_cyc, "R11 burst cyc held", {rd_cyc, wr_cyc}, 3);
                else if (rd_stb)
                    chk(!wr_cyc, "R11 single wr cyc idle", wr_cyc, 0);
                else
                    chk(!rd_cyc, "R11 single rd cyc idle", rd_cyc, 0);
            end
            // read port
            if (rd_stb) begin
                chk(rd_adr == ex_src + rd_idx * BY, "R4 read address", rd_adr, ex_src + rd_idx * BY);
                chk(rd_cti == cti_exp(rd_idx), "R11 read cti", rd_cti, cti_exp(rd_idx));
                if (rd_gap_on) begin
                    chk(rd_gap == rd_gap_exp, "R7 R8 read backoff gap", rd_gap, rd_gap_exp);
                    rd_gap_on = 0;
                end
                if (slow && !rd_held) begin
                    rd_held = 1;
                end else begin
                    rd_held = 0;
                    if (rd_idx == rd_err_idx) begin
                        rd_err = 1; err_last = 1;
                    end else if (rd_idx == rd_rty_word && rd_rty_cnt < rd_rty_times) begin
                        rd_rty = 1; rd_rty_cnt++;
                        rd_gap_on = 1; rd_gap = 0; rd_gap_exp = RW;
                    end else begin
                        rd_ack = 1; rd_dat = srcdat(rd_adr); rd_idx++;
                    end
                end
            end else begin
                if (rd_held) begin
                    chk(0, "R6 read strobe dropped early", 0, 1);
                    rd_held = 0;
                end
                if (rd_gap_on) begin
                    rd_gap++;
                    if (rd_reload_at != 0 && rd_gap == rd_reload_at) begin
                        rd_rty = 1; rd_gap_exp = rd_gap + RW; rd_reload_at = 0;
                    end
                end
            end
            // write port
            if (wr_stb) begin
                chk(wr_adr == ex_dst + wr_idx * BY, "R4 write address", wr_adr, ex_dst + wr_idx * BY);
                chk(wr_dat == srcdat(ex_src + wr_idx * BY), "R4 write data", wr_dat,
                    srcdat(ex_src + wr_idx * BY));
                chk(wr_cti == cti_exp(wr_idx), "R11 write cti", wr_cti, cti_exp(wr_idx));
                if (wr_gap_on) begin
                    chk(wr_gap == wr_gap_exp, "R7 write backoff gap", wr_gap, wr_gap_exp);
                    wr_gap_on = 0;
                end
                if (slow && !wr_held) begin
                    wr_held = 1;
                end else begin
                    wr_held = 0;
                    if (wr_idx == wr_err_idx) begin
                        wr_err = 1; err_last = 1;
                    end else if (wr_idx == wr_rty_word && wr_rty_cnt < wr_rty_times) begin
                        wr_rty = 1; wr_rty_cnt++;
                        wr_gap_on = 1; wr_gap = 0; wr_gap_exp = RW;
                    end else begin
                        wr_ack = 1; wr_idx++;
                    end
                end
            end else begin
                if (wr_held) begin
                    chk(0, "R6 write strobe dropped early", 0, 1);
                    wr_held = 0;
                end
                if (wr_gap_on) wr_gap++;
            end
        end
    end

    task automatic ctl_access(input bit we, input logic [1:0] idx, input logic [31:0] wd,
                              output logic [31:0] rdv);
        int waited;
        @(negedge clk);
        ctl_cyc = 1; ctl_stb = 1; ctl_we = we; ctl_adr = idx; ctl_wdat = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!ctl_ack && waited < 20);
        chk(ctl_ack && waited == 1, "R2 ack latency", waited, 1);
        rdv = ctl_rdat;
        ctl_cyc = 0; ctl_stb = 0; ctl_we = 0;
        @(negedge clk);
        chk(!ctl_ack, "R2 single-cycle ack", ctl_ack, 0);
    endtask

    task automatic wr_reg(input logic [1:0] idx, input logic [31:0] v);
        logic [31:0] dummy;
        ctl_access(1, idx, v, dummy);
    endtask

    task automatic rd_reg(input logic [1:0] idx, output logic [31:0] v);
        ctl_access(0, idx, 32'h0, v);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] dd, input int n, input bit bm);
        ex_src = s; ex_dst = dd; ex_len = n; burst_mode = bm;
        rd_idx = 0; wr_idx = 0; rd_rty_cnt = 0; wr_rty_cnt = 0;
    endtask

    task automatic clear_script();
        rd_err_idx = -1; wr_err_idx = -1;
        rd_rty_word = -1; rd_rty_times = 0; rd_reload_at = 0;
        wr_rty_word = -1; wr_rty_times = 0;
        slow = 0;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        int k = 0;
        do begin
            rd_reg(2'd3, st);
            k++;
        end while (st[0] && k < 400);
    endtask

    task automatic run_copy(input logic [31:0] s, input logic [31:0] dd, input int n,
                            input bit bm, output logic [31:0] st);
        wr_reg(2'd0, s);
        wr_reg(2'd1, dd);
        wr_reg(2'd2, n);
        setup(s, dd, n, bm);
        wr_reg(2'd3, bm ? 32'h3 : 32'h1);
        wait_idle(st);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        clear_script();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!rd_cyc && !rd_stb && !wr_cyc && !wr_stb && !ctl_ack, "R1 outputs after reset",
            {rd_cyc, rd_stb, wr_cyc, wr_stb, ctl_ack}, 0);
        rd_reg(2'd3, v); chk(v == 0, "R1 status after reset", v, 0);
        rd_reg(2'd0, v); chk(v == 0, "R1 source after reset", v, 0);
        rd_reg(2'd1, v); chk(v == 0, "R1 destination after reset", v, 0);

        // R2 register readback
        wr_reg(2'd0, 32'h0000_1000);
        wr_reg(2'd1, 32'h0000_2000);
        wr_reg(2'd2, 32'h0001_0003);
        rd_reg(2'd0, v); chk(v == 32'h1000, "R2 source readback", v, 32'h1000);
        rd_reg(2'd1, v); chk(v == 32'h2000, "R2 destination readback", v, 32'h2000);
        rd_reg(2'd2, v); chk(v == 32'h3, "R2 length readback truncated", v, 3);

        // R3 R4 R6 single copy with wait states
        slow = 1;
        run_copy(32'h1000, 32'h2000, 3, 0, v);
        chk(v == 32'h2, "R3 R4 status done", v, 2);
        chk(rd_idx == 3 && wr_idx == 3, "R4 word count moved", wr_idx, 3);
        rd_reg(2'd0, v); chk(v == 32'h100C, "R4 source advanced", v, 32'h100C);
        rd_reg(2'd1, v); chk(v == 32'h200C, "R4 destination advanced", v, 32'h200C);
        rd_reg(2'd2, v); chk(v == 0, "R4 length reaches zero", v, 0);
        clear_script();

        // R7 R8 retries on both ports, with reload in the first read gap
        rd_rty_word = 1; rd_rty_times = 2; rd_reload_at = 3;
        wr_rty_word = 0; wr_rty_times = 1;
        run_copy(32'h3000, 32'h4000, 3, 0, v);
        chk(v == 32'h2, "R7 status done after retries", v, 2);
        chk(wr_idx == 3 && rd_rty_cnt == 2 && wr_rty_cnt == 1, "R7 retried cycles completed",
            wr_idx, 3);
        clear_script();

        // R11 burst copy with a write retry
        wr_rty_word = 2; wr_rty_times = 1;
        run_copy(32'h5000, 32'h6000, 4, 1, v);
        chk(v == 32'hA, "R11 burst status done", v, 32'hA);
        chk(wr_idx == 4, "R11 burst words written", wr_idx, 4);
        clear_script();

        // R5 zero length
        wr_reg(2'd2, 0);
        setup(32'h6010, 32'h7000, 0, 0);
        quiet = 1;
        wr_reg(2'd3, 32'h1);
        repeat (8) @(negedge clk);
        rd_reg(2'd3, v); chk(v == 32'h2, "R5 zero length done", v, 2);
        quiet = 0;

        // R10 writes while busy are ignored
        wr_reg(2'd0, 32'h8000);
        wr_reg(2'd1, 32'h9000);
        wr_reg(2'd2, 4);
        setup(32'h8000, 32'h9000, 4, 0);
        rd_rty_word = 0; rd_rty_times = 3;
        wr_reg(2'd3, 32'h1);
        wr_reg(2'd0, 32'hAAAA_0000);
        wr_reg(2'd2, 1);
        wr_reg(2'd3, 32'h3);
        rd_reg(2'd3, v); chk(v == 32'h1, "R10 busy status unchanged", v, 1);
        wait_idle(v);
        chk(v == 32'h2, "R10 copy finished in single mode", v, 2);
        rd_reg(2'd0, v); chk(v == 32'h8010, "R10 source write ignored", v, 32'h8010);
        chk(wr_idx == 4, "R10 length write ignored", wr_idx, 4);
        clear_script();

        // R9 read error on the second word
        rd_err_idx = 1;
        run_copy(32'hA000, 32'hB000, 3, 0, v);
        chk(v == 32'h4, "R9 read error status", v, 4);
        rd_reg(2'd2, v); chk(v == 2, "R9 length after read error", v, 2);
        rd_reg(2'd0, v); chk(v == 32'hA004, "R9 source after read error", v, 32'hA004);
        clear_script();

        // R9 write error on the first word, then R3 restart clears it
        wr_err_idx = 0;
        run_copy(32'hC000, 32'hD000, 2, 1, v);
        chk(v == 32'hC, "R9 write error status", v, 32'hC);
        rd_reg(2'd2, v); chk(v == 2, "R9 length after write error", v, 2);
        rd_reg(2'd1, v); chk(v == 32'hD000, "R9 destination after write error", v, 32'hD000);
        clear_script();
        setup(32'hC000, 32'hD000, 2, 0);
        wr_reg(2'd3, 32'h1);
        wait_idle(v);
        chk(v == 32'h2, "R3 restart clears error", v, 2);
        chk(wr_idx == 2, "R3 restart words written", wr_idx, 2);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule